// File: doc/BRIEF.md
# I2C Channel Command and Control Register

This block is the 16-bit control word of one I2C channel. It sits between a CPU register port and the bus engine that drives SCL and SDA. The port is a write strobe with write data, plus a combinational read-data bus. The block keeps two plain settings: the channel enable, which gates the engine clock, and the master/slave selection. It also takes four one-shot commands. Three of them ask the engine for a START, a STOP or a NACK. The fourth runs a software reset of the transfer logic and a clear of the interrupt flags.

Each command bit reads back 1 for as long as its request is waiting or being carried out, and it clears itself when its completion condition is met. START and NACK clear on the engine's matching done pulse. STOP stays set after the engine reports that the STOP is done, until a bus-free interval of `BUS_FREE_CYCLES` clocks has also passed. Software reset holds a reset line to the engine for a fixed `SRST_CYCLES` clocks.

Three small state machines carry the commands:
- Request bit (used for both START and NACK), states `REQ_IDLE` and `REQ_PENDING`.
  - `REQ_IDLE` goes to `REQ_PENDING` on a set.
  - `REQ_PENDING` goes back to `REQ_IDLE` on a done pulse with no set in the same cycle, or on a clear.
- STOP sequencer, states `STP_IDLE`, `STP_WAIT_DONE` and `STP_BUS_FREE`.
  - `STP_IDLE` goes to `STP_WAIT_DONE` on a request.
  - `STP_WAIT_DONE` goes to `STP_BUS_FREE` on stop-done, which also loads the counter.
  - `STP_BUS_FREE` goes to `STP_IDLE` when the counter leaves 1.
  - A clear sends either busy state to `STP_IDLE`.
- Software reset sequencer, states `SR_IDLE` and `SR_ACTIVE`.
  - `SR_IDLE` goes to `SR_ACTIVE` on a write of 1 to the reset bit.
  - `SR_ACTIVE` goes back to `SR_IDLE` after `SRST_CYCLES` cycles.

Top module: `i2c_ctl_reg`

## Requirements
- R1: Bits 15..6 of `rd_data` always read 0, and writing 1 to them changes nothing.
- R2: Bit 0 (enable) is read/write. `eng_clk_en` equals the stored bit.
- R3: Bit 5 (mode, 1 = master) is read/write. `eng_master` equals the stored bit.
- R4: Writing 1 to bit 2 while the mode already held is master sets bit 2 and raises `start_req` from the next cycle. With slave mode held, the write leaves bit 2 at 0.
- R5: Bit 2 and `start_req` clear in the cycle after `start_done` is sampled. If a START set and `start_done` arrive in the same cycle, the bit stays 1.
- R6: Writing 1 to bit 3 while master mode is held sets bit 3 and `stop_req`. With slave mode held, the write has no effect.
- R7: `stop_req` drops in the cycle after `stop_done` is sampled, while bit 3 stays 1 for exactly `BUS_FREE_CYCLES` further cycles and then reads 0.
- R8: Writing 1 to bit 4 sets it and `nack_req` in either mode. It clears after `nack_done`. A set in the same cycle as `nack_done` wins.
- R9: Writing 0 to any of bits 1..4 leaves that bit unchanged.
- R10: Writing 1 to bit 1 makes bit 1 and `eng_srst` read 1 for exactly `SRST_CYCLES` cycles, starting the cycle after the write. `irq_flag_clr` pulses once, in the first of those cycles.
- R11: A software reset clears bits 2..4 from the cycle after its write and abandons any bus-free wait. Writes of 1 to bits 2..4 are ignored while it runs. Bits 0 and 5 are kept.
- R12: Hardware reset (`rst_n` low) forces every bit and every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| start_done | input | 1 | Engine pulse: START generated |
| stop_done | input | 1 | Engine pulse: STOP generated |
| nack_done | input | 1 | Engine pulse: NACK sent |
| eng_clk_en | output | 1 | Engine clock enable |
| eng_master | output | 1 | Engine master mode select |
| start_req | output | 1 | START request to engine |
| stop_req | output | 1 | STOP request to engine, dropped once the STOP is done |
| nack_req | output | 1 | NACK request to engine |
| eng_srst | output | 1 | Reset to the transfer-control logic |
| irq_flag_clr | output | 1 | One-cycle clear strobe to the interrupt flags |

## Verification
The assertions check several rules on every cycle:
- A set request becomes pending, and a pending request with a lone done pulse falls back to idle.
- Stop-done loads the full bus-free count, and that count never reaches zero inside the wait state.
- A started software reset leaves its active state once its count is spent, and no command request is live while it runs.
- A slave-mode START write leaves the START bit clear.

Only the bench scenarios can show the exact lengths of the bus-free window and the reset window at the ports. They also show the same-cycle set-and-done ordering, the reserved bits reading zero after writes of all ones, and enable and mode surviving a software reset.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
    localparam int REG_W     = 16;
    localparam int BIT_EN    = 0;
    localparam int BIT_SRST  = 1;
    localparam int BIT_START = 2;
    localparam int BIT_STOP  = 3;
    localparam int BIT_NACK  = 4;
    localparam int BIT_MODE  = 5;
    localparam int USED_W    = BIT_MODE + 1;

    typedef enum logic {REQ_IDLE, REQ_PENDING} req_state_e;
    typedef enum logic [1:0] {STP_IDLE, STP_WAIT_DONE, STP_BUS_FREE} stop_state_e;
    typedef enum logic {SR_IDLE, SR_ACTIVE} srst_state_e;
endpackage

// File: rtl/i2c_ctl_req_bit.sv
module i2c_ctl_req_bit
    import i2c_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic done_i,
    input  logic clr_i,
    output logic pend_o
);
    req_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:    if (set_i && !clr_i) state_d = REQ_PENDING;
            REQ_PENDING: begin
                if (clr_i)                  state_d = REQ_IDLE;
                else if (done_i && !set_i)  state_d = REQ_IDLE;
            end
            default:     state_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == REQ_PENDING);
    end

    // R5
    req_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && done_i && !set_i && !clr_i) |=> !pend_o);
    // R8
    req_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> pend_o);
endmodule

// File: rtl/i2c_ctl_stop_seq.sv
module i2c_ctl_stop_seq
    import i2c_ctl_pkg::*;
#(
    parameter int BUS_FREE_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic done_i,
    input  logic clr_i,
    output logic busy_o,
    output logic stop_req_o
);
    localparam int CNT_W = $clog2(BUS_FREE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUS_FREE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    stop_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            STP_IDLE: begin
                if (set_i && !clr_i) state_d = STP_WAIT_DONE;
            end
            STP_WAIT_DONE: begin
                if (clr_i) begin
                    state_d = STP_IDLE;
                end else if (done_i) begin
                    state_d = STP_BUS_FREE;
                    cnt_d   = CNT_LOAD;
                end
            end
            STP_BUS_FREE: begin
                if (clr_i || cnt_q == CNT_ONE) begin
                    state_d = STP_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            default: begin
                state_d = STP_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        busy_o     = (state_q != STP_IDLE);
        stop_req_o = (state_q == STP_WAIT_DONE);
    end

    // R7
    stop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == STP_WAIT_DONE && done_i && !clr_i) |=>
            (state_q == STP_BUS_FREE && cnt_q == CNT_LOAD));
    // R7
    bus_free_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == STP_BUS_FREE) |-> (cnt_q != '0));
    // R7
    stop_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req_o && done_i && !clr_i) |=> (!stop_req_o && busy_o));
endmodule

// File: rtl/i2c_ctl_srst_seq.sv
module i2c_ctl_srst_seq
    import i2c_ctl_pkg::*;
#(
    parameter int SRST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o,
    output logic irq_clr_o
);
    localparam int CNT_W = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    srst_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SR_IDLE: begin
                if (go_i) begin
                    state_d = SR_ACTIVE;
                    cnt_d   = CNT_LOAD;
                end
            end
            SR_ACTIVE: begin
                if (cnt_q == '0) state_d = SR_IDLE;
                else             cnt_d   = cnt_q - CNT_ONE;
            end
            default: state_d = SR_IDLE;
        endcase
    end

    always_comb begin
        busy_o    = (state_q == SR_ACTIVE);
        irq_clr_o = (state_q == SR_ACTIVE) && (cnt_q == CNT_LOAD);
    end

    // R10
    srst_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !busy_o) |=> (busy_o && irq_clr_o));
    // R10
    srst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q == '0) |=> !busy_o);
    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_o |=> !irq_clr_o);
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
    import i2c_ctl_pkg::*;
#(
    parameter int BUS_FREE_CYCLES = 50,
    parameter int SRST_CYCLES     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        start_done,
    input  logic        stop_done,
    input  logic        nack_done,
    output logic        eng_clk_en,
    output logic        eng_master,
    output logic        start_req,
    output logic        stop_req,
    output logic        nack_req,
    output logic        eng_srst,
    output logic        irq_flag_clr
);
    logic en_q, mode_q;
    logic srst_busy, srst_go, cmd_clr;
    logic start_set, stop_set, nack_set;
    logic start_pend, stop_busy, nack_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
        end else if (wr_en) begin
            en_q   <= wr_data[BIT_EN];
            mode_q <= wr_data[BIT_MODE];
        end
    end

    always_comb begin
        srst_go   = wr_en && wr_data[BIT_SRST] && !srst_busy;
        cmd_clr   = srst_go || srst_busy;
        start_set = wr_en && wr_data[BIT_START] && mode_q;
        stop_set  = wr_en && wr_data[BIT_STOP]  && mode_q;
        nack_set  = wr_en && wr_data[BIT_NACK];
    end

    i2c_ctl_req_bit u_start (
        .clk(clk), .rst_n(rst_n), .set_i(start_set), .done_i(start_done),
        .clr_i(cmd_clr), .pend_o(start_pend)
    );

    i2c_ctl_req_bit u_nack (
        .clk(clk), .rst_n(rst_n), .set_i(nack_set), .done_i(nack_done),
        .clr_i(cmd_clr), .pend_o(nack_pend)
    );

    i2c_ctl_stop_seq #(.BUS_FREE_CYCLES(BUS_FREE_CYCLES)) u_stop (
        .clk(clk), .rst_n(rst_n), .set_i(stop_set), .done_i(stop_done),
        .clr_i(cmd_clr), .busy_o(stop_busy), .stop_req_o(stop_req)
    );

    i2c_ctl_srst_seq #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
        .clk(clk), .rst_n(rst_n), .go_i(srst_go),
        .busy_o(srst_busy), .irq_clr_o(irq_flag_clr)
    );

    always_comb begin
        rd_data              = '0;
        rd_data[BIT_EN]      = en_q;
        rd_data[BIT_SRST]    = srst_busy;
        rd_data[BIT_START]   = start_pend;
        rd_data[BIT_STOP]    = stop_busy;
        rd_data[BIT_NACK]    = nack_pend;
        rd_data[BIT_MODE]    = mode_q;
        eng_clk_en           = en_q;
        eng_master           = mode_q;
        start_req            = start_pend;
        nack_req             = nack_pend;
        eng_srst             = srst_busy;
    end

    // R11
    srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (!start_req && !stop_req && !nack_req));
    // R11
    srst_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_busy && !wr_en) |=> ($stable(eng_clk_en) && $stable(eng_master)));
    // R4
    slave_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_START] && !eng_master && !start_req) |=> !start_req);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[REG_W-1:USED_W] == '0));
endmodule

// File: tb/i2c_ctl_reg_test.sv
module i2c_ctl_reg_test;
    localparam int BF  = 3;
    localparam int SRC = 4;
    localparam int NV  = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        start_done = 1'b0, stop_done = 1'b0, nack_done = 1'b0;
    logic [15:0] rd_data;
    logic        eng_clk_en, eng_master, start_req, stop_req, nack_req, eng_srst, irq_flag_clr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    i2c_ctl_reg #(.BUS_FREE_CYCLES(BF), .SRST_CYCLES(SRC)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .start_done(start_done), .stop_done(stop_done), .nack_done(nack_done),
        .eng_clk_en(eng_clk_en), .eng_master(eng_master), .start_req(start_req),
        .stop_req(stop_req), .nack_req(nack_req), .eng_srst(eng_srst),
        .irq_flag_clr(irq_flag_clr)
    );

    // {wr_en, wr_data, start_done, stop_done, nack_done, expected rd_data after the edge}
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 16'hFFC1, 3'b000, 16'h0001}, // R1 R2 reserved ignored, enable
        {1'b1, 16'h0021, 3'b000, 16'h0021}, // R3 master
        {1'b1, 16'h0025, 3'b000, 16'h0025}, // R4 start set
        {1'b0, 16'h0000, 3'b000, 16'h0025}, // R4 held
        {1'b0, 16'h0000, 3'b100, 16'h0021}, // R5 start done
        {1'b1, 16'h0025, 3'b100, 16'h0025}, // R5 set wins
        {1'b0, 16'h0000, 3'b100, 16'h0021}, // R5 later done
        {1'b1, 16'h0029, 3'b000, 16'h0029}, // R6 stop set
        {1'b0, 16'h0000, 3'b010, 16'h0029}, // R7 stop done, bus free 1
        {1'b0, 16'h0000, 3'b000, 16'h0029}, // R7 bus free 2
        {1'b0, 16'h0000, 3'b000, 16'h0029}, // R7 bus free 3
        {1'b0, 16'h0000, 3'b000, 16'h0021}, // R7 cleared
        {1'b1, 16'h0031, 3'b000, 16'h0031}, // R8 nack set
        {1'b1, 16'h0001, 3'b000, 16'h0011}, // R9 zero write keeps nack, R3 slave
        {1'b1, 16'h0005, 3'b000, 16'h0011}, // R4 slave start ignored
        {1'b1, 16'h0009, 3'b000, 16'h0011}, // R6 slave stop ignored
        {1'b0, 16'h0000, 3'b001, 16'h0001}, // R8 nack done
        {1'b1, 16'h0015, 3'b000, 16'h0011}, // R8 nack in slave mode
        {1'b1, 16'h0011, 3'b001, 16'h0011}, // R8 set wins
        {1'b0, 16'h0000, 3'b001, 16'h0001}, // R8 done
        {1'b1, 16'h0021, 3'b000, 16'h0021}, // R3 master again
        {1'b1, 16'h0035, 3'b000, 16'h0035}, // R4 R8 start and nack
        {1'b1, 16'h0023, 3'b000, 16'h0023}, // R10 R11 soft reset clears
        {1'b1, 16'h003D, 3'b000, 16'h0023}, // R11 writes ignored
        {1'b0, 16'h0000, 3'b000, 16'h0023}, // R10 active 3
        {1'b0, 16'h0000, 3'b000, 16'h0023}, // R10 active 4
        {1'b0, 16'h0000, 3'b000, 16'h0021}, // R10 finished
        {1'b1, 16'h0029, 3'b000, 16'h0029}, // R6 stop
        {1'b0, 16'h0000, 3'b010, 16'h0029}, // R7 bus free
        {1'b1, 16'h0023, 3'b000, 16'h0023}, // R11 abandon bus free
        {1'b0, 16'h0000, 3'b010, 16'h0023}, // R11 stray done
        {1'b0, 16'h0000, 3'b000, 16'h0023}, // R10
        {1'b0, 16'h0000, 3'b000, 16'h0023}, // R10
        {1'b0, 16'h0000, 3'b000, 16'h0021}  // R11 mode and enable kept
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [15:0] d, input logic [2:0] dn);
        wr_en = w; wr_data = d; {start_done, stop_done, nack_done} = dn;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; {start_done, stop_done, nack_done} = 3'b000;
    endtask

    initial begin
        int n;
        int irqs;
        @(negedge clk); @(negedge clk);
        chk("R12 reset rd", rd_data, 16'h0000);
        chk("R12 reset outputs", {9'd0, eng_clk_en, eng_master, start_req, stop_req,
            nack_req, eng_srst, irq_flag_clr}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i][35];
            wr_data = VEC[i][34:19];
            {start_done, stop_done, nack_done} = VEC[i][18:16];
            @(negedge clk);
            checks++;
            if (rd_data !== VEC[i][15:0]) begin
                fails++;
                $display("FAIL table step %0d (R1..R12 per row): actual %h expected %h",
                         i, rd_data, VEC[i][15:0]);
            end
        end
        wr_en = 1'b0; wr_data = '0; {start_done, stop_done, nack_done} = 3'b000;

        // R2 R3 R4 engine-side outputs
        cyc(1'b1, 16'h0025, 3'b000);
        chk("R2 clk enable", {15'd0, eng_clk_en}, 16'h0001);
        chk("R3 master out", {15'd0, eng_master}, 16'h0001);
        chk("R4 start_req", {15'd0, start_req}, 16'h0001);
        cyc(1'b0, 16'h0000, 3'b100);
        chk("R5 start_req cleared", {15'd0, start_req}, 16'h0000);

        // R6 R7 stop request and bus-free window
        cyc(1'b1, 16'h0029, 3'b000);
        chk("R6 stop_req", {15'd0, stop_req}, 16'h0001);
        cyc(1'b0, 16'h0000, 3'b010);
        chk("R7 stop_req drop", {15'd0, stop_req}, 16'h0000);
        chk("R7 stop bit held", {15'd0, rd_data[3]}, 16'h0001);
        n = 0;
        while (rd_data[3] && n < 100) begin @(negedge clk); n++; end
        chk("R7 bus-free length", 16'(n), 16'(BF));

        // R10 soft reset length and single clear strobe
        cyc(1'b1, 16'h0033, 3'b000);
        chk("R8 nack_req cleared by R11 reset", {15'd0, nack_req}, 16'h0000);
        n = 0; irqs = 0;
        while (eng_srst && n < 100) begin
            if (irq_flag_clr) irqs++;
            @(negedge clk); n++;
        end
        chk("R10 eng_srst length", 16'(n), 16'(SRC));
        chk("R10 irq_flag_clr pulses", 16'(irqs), 16'h0001);
        chk("R11 config kept", rd_data, 16'h0021);

        // R12 hardware reset mid-operation
        cyc(1'b1, 16'h0031, 3'b000);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 hw reset rd", rd_data, 16'h0000);
        chk("R12 hw reset nack_req", {15'd0, nack_req}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule